// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two data buses, A and B, through a pair of storage registers, one for each direction of travel. The A-to-B register takes a copy of bus A whenever its capture strobe is high at a clock edge. The B-to-A register does the same with bus B and its own strobe. Whichever bus is driven carries either live data taken straight from the opposite bus or the value held in the register for that direction. A per-direction select input makes that choice.

An active-low output enable and a direction input decide which bus, if any, the block drives. Capture is never gated by these two inputs. The registers keep loading and holding while both buses are released, so data can be parked and then replayed later.

The width is split into independent sections, two sections of eight bits by default. Each section has its own enable, direction, capture strobes and selects. Tying the controls of all sections together gives one wide transceiver. Pads are modelled as separate input, output and output-enable signals. All capture happens in the one system clock domain, and each capture strobe is a synchronous enable.

Top module: `bus_xcvr_reg`

## Requirements
- R1: When `cap_ab_i[s]` is high at a rising clock edge, the A-to-B register of section s takes the value of `a_in_i` for that section. The new value is visible from the next cycle.
- R2: When `cap_ba_i[s]` is high at a rising clock edge, the B-to-A register of section s takes the value of `b_in_i` for that section. The new value is visible from the next cycle.
- R3: Capture works the same for every value of `oe_ni` and `dir_i`. A register whose strobe is low keeps its value, including in isolation.
- R4: When `oe_ni[s]` is 1, `a_oe_o[s]` and `b_oe_o[s]` are both 0.
- R5: When `oe_ni[s]` is 0 and `dir_i[s]` is 0, bus A is driven: `a_oe_o[s]`=1 and `b_oe_o[s]`=0.
- R6: When `oe_ni[s]` is 0 and `dir_i[s]` is 1, bus B is driven: `b_oe_o[s]`=1 and `a_oe_o[s]`=0. The two enables of a section are never 1 together.
- R7: While B is driven, `sel_ab_i[s]`=0 puts the live `a_in_i` slice on `b_out_o`. `sel_ab_i[s]`=1 puts the A-to-B register value there instead.
- R8: While A is driven, `sel_ba_i[s]`=0 puts the live `b_in_i` slice on `a_out_o`. `sel_ba_i[s]`=1 puts the B-to-A register value there instead.
- R9: Section s occupies bits [s*8+7 : s*8] and depends only on its own controls and its own data slices.
- R10: An active-low asynchronous reset `rst_ni` clears both registers of every section to zero.
- R11: The output data slice of a bus that is not driven in a section reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_ni | input | NUM_SEC | Output enable per section, active low |
| dir_i | input | NUM_SEC | Direction per section: 0 drives A, 1 drives B |
| cap_ab_i | input | NUM_SEC | Capture strobe for the A-to-B register |
| cap_ba_i | input | NUM_SEC | Capture strobe for the B-to-A register |
| sel_ab_i | input | NUM_SEC | Source for bus B: 0 live, 1 stored |
| sel_ba_i | input | NUM_SEC | Source for bus A: 0 live, 1 stored |
| a_in_i | input | NUM_SEC*SEC_W | Data seen at the A pads |
| b_in_i | input | NUM_SEC*SEC_W | Data seen at the B pads |
| a_out_o | output | NUM_SEC*SEC_W | Data toward the A pads |
| a_oe_o | output | NUM_SEC | Drive enable for the A pads per section |
| b_out_o | output | NUM_SEC*SEC_W | Data toward the B pads |
| b_oe_o | output | NUM_SEC | Drive enable for the B pads per section |

## Verification
The bench runs through every combination of the six control bits in each section. It gives the two sections different control patterns on the same cycles and keeps an arithmetic model of the four registers. This is aimed first at the live-versus-stored selects. If a select were swapped or tied to the wrong register, the driven bus would show the opposite bus's live data where a stored value is expected, or the reverse. A second target is capture during isolation or in the opposite direction. If capture were gated by the enable or the direction, stored values would go stale and a later replay would show old data. The bench also watches for cross-talk between sections, which would show up as one section's enables or data following the other section's controls. Finally, a wrong enable decode would turn on both pad enables at once, or drive a bus while the output enable is inactive.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  typedef enum logic {
    DRV_A = 1'b0,
    DRV_B = 1'b1
  } side_e;

  typedef struct packed {
    logic oe_n;
    logic dir;
    logic cap_ab;
    logic cap_ba;
    logic sel_ab;
    logic sel_ba;
  } sec_ctl_t;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
  import xcvr_pkg::*;
#(
  parameter int    W    = 8,
  parameter side_e SIDE = DRV_A
) (
  input  logic         oe_ni,
  input  logic         dir_i,
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] out_o,
  output logic         oe_o
);
  src_e src;

  always_comb begin
    src   = src_e'(sel_i);
    oe_o  = !oe_ni && (dir_i == logic'(SIDE));
    out_o = '0;
    if (oe_o) out_o = (src == SRC_STORED) ? stored_i : live_i;
  end
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  sec_ctl_t     ctl_i,
  input  logic [W-1:0] a_in_i,
  input  logic [W-1:0] b_in_i,
  output logic [W-1:0] a_out_o,
  output logic         a_oe_o,
  output logic [W-1:0] b_out_o,
  output logic         b_oe_o,
  output logic [W-1:0] q_ab_o,
  output logic [W-1:0] q_ba_o
);
  xcvr_store #(.W(W)) u_st_ab (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(ctl_i.cap_ab),
    .d_i   (a_in_i), .q_o  (q_ab_o)
  );

  xcvr_store #(.W(W)) u_st_ba (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(ctl_i.cap_ba),
    .d_i   (b_in_i), .q_o  (q_ba_o)
  );

  xcvr_drive #(.W(W), .SIDE(DRV_A)) u_drv_a (
    .oe_ni   (ctl_i.oe_n), .dir_i (ctl_i.dir), .sel_i(ctl_i.sel_ba),
    .live_i  (b_in_i),     .stored_i(q_ba_o),
    .out_o   (a_out_o),    .oe_o  (a_oe_o)
  );

  xcvr_drive #(.W(W), .SIDE(DRV_B)) u_drv_b (
    .oe_ni   (ctl_i.oe_n), .dir_i (ctl_i.dir), .sel_i(ctl_i.sel_ab),
    .live_i  (a_in_i),     .stored_i(q_ab_o),
    .out_o   (b_out_o),    .oe_o  (b_oe_o)
  );
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int NUM_SEC = 2,
  parameter int SEC_W   = 8,
  localparam int W      = NUM_SEC * SEC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SEC-1:0] oe_ni,
  input  logic [NUM_SEC-1:0] dir_i,
  input  logic [NUM_SEC-1:0] cap_ab_i,
  input  logic [NUM_SEC-1:0] cap_ba_i,
  input  logic [NUM_SEC-1:0] sel_ab_i,
  input  logic [NUM_SEC-1:0] sel_ba_i,
  input  logic [W-1:0]       a_in_i,
  input  logic [W-1:0]       b_in_i,
  output logic [W-1:0]       a_out_o,
  output logic [NUM_SEC-1:0] a_oe_o,
  output logic [W-1:0]       b_out_o,
  output logic [NUM_SEC-1:0] b_oe_o
);
  logic [W-1:0] q_ab;
  logic [W-1:0] q_ba;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    sec_ctl_t ctl;

    always_comb begin
      ctl.oe_n   = oe_ni[s];
      ctl.dir    = dir_i[s];
      ctl.cap_ab = cap_ab_i[s];
      ctl.cap_ba = cap_ba_i[s];
      ctl.sel_ab = sel_ab_i[s];
      ctl.sel_ba = sel_ba_i[s];
    end

    xcvr_section #(.W(SEC_W)) u_sec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctl_i  (ctl),
      .a_in_i (a_in_i[s*SEC_W +: SEC_W]),
      .b_in_i (b_in_i[s*SEC_W +: SEC_W]),
      .a_out_o(a_out_o[s*SEC_W +: SEC_W]),
      .a_oe_o (a_oe_o[s]),
      .b_out_o(b_out_o[s*SEC_W +: SEC_W]),
      .b_oe_o (b_oe_o[s]),
      .q_ab_o (q_ab[s*SEC_W +: SEC_W]),
      .q_ba_o (q_ba[s*SEC_W +: SEC_W])
    );
  end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int NUM_SEC = 2,
  parameter int SEC_W   = 8,
  localparam int W      = NUM_SEC * SEC_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SEC-1:0] oe_ni,
  input logic [NUM_SEC-1:0] dir_i,
  input logic [NUM_SEC-1:0] cap_ab_i,
  input logic [NUM_SEC-1:0] cap_ba_i,
  input logic [NUM_SEC-1:0] sel_ab_i,
  input logic [NUM_SEC-1:0] sel_ba_i,
  input logic [W-1:0]       a_in_i,
  input logic [W-1:0]       b_in_i,
  input logic [W-1:0]       a_out_o,
  input logic [NUM_SEC-1:0] a_oe_o,
  input logic [W-1:0]       b_out_o,
  input logic [NUM_SEC-1:0] b_oe_o,
  input logic [W-1:0]       q_ab,
  input logic [W-1:0]       q_ba
);
  a_r10_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (q_ab == '0 && q_ba == '0));

  a_r6_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o & b_oe_o) == '0);

  a_r4_isolate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_oe_o | b_oe_o) & oe_ni) == '0);

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_s
    a_r1_capture_ab: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_ab_i[s] |=> q_ab[s*SEC_W +: SEC_W] == $past(a_in_i[s*SEC_W +: SEC_W]));

    a_r2_capture_ba: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_ba_i[s] |=> q_ba[s*SEC_W +: SEC_W] == $past(b_in_i[s*SEC_W +: SEC_W]));

    a_r3_hold_ab: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_ab_i[s] |=> $stable(q_ab[s*SEC_W +: SEC_W]));

    a_r3_hold_ba: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_ba_i[s] |=> $stable(q_ba[s*SEC_W +: SEC_W]));

    a_r7_b_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!oe_ni[s] && dir_i[s] && sel_ab_i[s]) |->
        b_out_o[s*SEC_W +: SEC_W] == q_ab[s*SEC_W +: SEC_W]);

    a_r8_a_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!oe_ni[s] && !dir_i[s] && sel_ba_i[s]) |->
        a_out_o[s*SEC_W +: SEC_W] == q_ba[s*SEC_W +: SEC_W]);

    a_r11_quiet_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !a_oe_o[s] |-> a_out_o[s*SEC_W +: SEC_W] == '0);

    a_r11_quiet_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !b_oe_o[s] |-> b_out_o[s*SEC_W +: SEC_W] == '0);
  end
endmodule

bind bus_xcvr_reg xcvr_chk #(.NUM_SEC(NUM_SEC), .SEC_W(SEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .oe_ni(oe_ni), .dir_i(dir_i),
  .cap_ab_i(cap_ab_i), .cap_ba_i(cap_ba_i), .sel_ab_i(sel_ab_i),
  .sel_ba_i(sel_ba_i), .a_in_i(a_in_i), .b_in_i(b_in_i),
  .a_out_o(a_out_o), .a_oe_o(a_oe_o), .b_out_o(b_out_o), .b_oe_o(b_oe_o),
  .q_ab(q_ab), .q_ba(q_ba)
);

// File: tb/sim_bus_xcvr_reg.sv
`timescale 1ns/1ps
module sim_bus_xcvr_reg;
  localparam int NS = 2;
  localparam int SW = 8;
  localparam int W  = NS * SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] oe_n, dir, cab, cba, sab, sba;
  logic [W-1:0]  a_in, b_in, a_out, b_out;
  logic [NS-1:0] a_oe, b_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [SW-1:0] m_ab [NS];
  logic [SW-1:0] m_ba [NS];

  always #5 clk = ~clk;

  bus_xcvr_reg #(.NUM_SEC(NS), .SEC_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .oe_ni(oe_n), .dir_i(dir),
    .cap_ab_i(cab), .cap_ba_i(cba), .sel_ab_i(sab), .sel_ba_i(sba),
    .a_in_i(a_in), .b_in_i(b_in), .a_out_o(a_out), .a_oe_o(a_oe),
    .b_out_o(b_out), .b_oe_o(b_oe)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // One cycle: drive at negedge, update model at posedge, compare just after.
  task automatic step(input logic [5:0] c0, input logic [5:0] c1,
                      input logic [W-1:0] a, input logic [W-1:0] b);
    logic [5:0] c [NS];
    logic [SW-1:0] ea, eb;
    logic [W-1:0] exp_aout, exp_bout;
    logic [NS-1:0] exp_aoe, exp_boe;
    c[0] = c0;
    c[1] = c1;
    @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      oe_n[s] = c[s][0];
      dir[s]  = c[s][1];
      cab[s]  = c[s][2];
      cba[s]  = c[s][3];
      sab[s]  = c[s][4];
      sba[s]  = c[s][5];
    end
    a_in = a;
    b_in = b;
    @(posedge clk);
    for (int s = 0; s < NS; s++) begin
      if (c[s][2]) m_ab[s] = a[s*SW +: SW];  // R1
      if (c[s][3]) m_ba[s] = b[s*SW +: SW];  // R2
    end
    #1;
    for (int s = 0; s < NS; s++) begin
      exp_aoe[s] = !c[s][0] && !c[s][1];
      exp_boe[s] = !c[s][0] &&  c[s][1];
      ea = !exp_aoe[s] ? '0 : (c[s][5] ? m_ba[s] : b[s*SW +: SW]);
      eb = !exp_boe[s] ? '0 : (c[s][4] ? m_ab[s] : a[s*SW +: SW]);
      exp_aout[s*SW +: SW] = ea;
      exp_bout[s*SW +: SW] = eb;
    end
    check("R4 R5 R6 a_oe", W'(a_oe), W'(exp_aoe));
    check("R4 R5 R6 b_oe", W'(b_oe), W'(exp_boe));
    check("R8 R11 R9 a_out", a_out, exp_aout);
    check("R7 R11 R9 b_out", b_out, exp_bout);
  endtask

  initial begin
    oe_n = '1; dir = '0; cab = '0; cba = '0; sab = '0; sba = '0;
    a_in = '0; b_in = '0;
    for (int s = 0; s < NS; s++) begin
      m_ab[s] = '0;
      m_ba[s] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset value read back through the stored paths, both sides.
    step(6'b110000, 6'b110000, 16'hA5A5, 16'h5A5A);  // A driven, stored
    check("R10 a_out zero after reset", a_out, '0);
    step(6'b110010, 6'b110010, 16'h1234, 16'h4321);  // B driven, stored
    check("R10 b_out zero after reset", b_out, '0);

    // R3: capture in isolation, then replay the stored values.
    step(6'b001101, 6'b001101, 16'hC3E1, 16'h7E18);
    step(6'b110010, 6'b110010, 16'h0000, 16'h0000);
    check("R3 R1 stored A-to-B after isolated capture", b_out, 16'hC3E1);
    step(6'b110000, 6'b110000, 16'hFFFF, 16'hFFFF);
    check("R3 R2 stored B-to-A after isolated capture", a_out, 16'h7E18);

    // R3: capture while driving the opposite bus, then hold without strobes.
    step(6'b001110, 6'b001110, 16'h9966, 16'h3355);
    step(6'b010010, 6'b100000, 16'h0101, 16'h0202);
    check("R3 hold A-to-B sec0", b_out, {8'h00, 8'h66});
    check("R3 hold B-to-A sec1", a_out, {8'h33, 8'h00});

    // Sweep: every control pattern per section, sections offset.
    for (int i = 0; i < 512; i++) begin
      step(6'(i), 6'(i * 7 + 13),
           {8'(i * 29 + 101), 8'(i * 53 + 3)},
           {8'(i * 37 + 200), 8'(i * 11 + 17)});
    end

    // R9: one section driven B stored, the other isolated while capturing.
    step(6'b011110, 6'b001101, 16'hBEEF, 16'hCAFE);
    step(6'b010010, 6'b000001, 16'h0000, 16'h0000);
    check("R9 sec0 B stored, sec1 quiet", b_out, {8'h00, 8'hEF});
    check("R9 sec1 enables off", {14'b0, a_oe[1], b_oe[1]}, '0);

    finish_run();
  end
endmodule